// File: doc/BRIEF.md
# SPI Master Serial-Clock Divider

This block derives the serial clock of an SPI master from the module clock. Two 3-bit fields set the ratio. A linear field, `presel_i`, sets a factor of `presel_i + 1`. An exponent field, `sel_i`, sets a factor of `2^(sel_i + 1)`. The full SCK period is the product of the two, so the block can produce both power-of-two ratios and other ratios such as 6 or 10.

The block puts out a one-cycle strobe, `sck_tick_o`, at every half-period boundary, and a divided clock level, `sck_o`, that flips after each strobe. The divider advances only while `master_i` and `xfer_i` are both high. At all other times the counter is held at zero and the clock level at low, so no divider logic switches between transfers.

The half-period length is captured whenever the divider is idle and again at every terminal count. A field change made during a transfer therefore applies only from the next half-period onward.

Top module: `spi_baud_div`

## Requirements
- R1: After reset, `sck_o` is 0 and `sck_tick_o` is 0.
- R2: With `presel_i` = 0 and `sel_i` = 0, the SCK period is 2 module clocks, so a strobe occurs in every enabled cycle.
- R3: With `presel_i` = 0, `sel_i` = 1 gives an SCK period of 4 module clocks and `sel_i` = 2 gives a period of 8.
- R4: `presel_i` = p multiplies the power-of-two period by p+1. For example, `presel_i` = 2 with `sel_i` = 0 gives a period of 6, and `presel_i` = 4 with `sel_i` = 0 gives a period of 10.
- R5: With both fields at 7, the period is 2048 module clocks and the strobes are 1024 cycles apart. The internal counter does not wrap early.
- R6: While `master_i` or `xfer_i` is low, no strobe occurs and `sck_o` is 0 from the following cycle on. If the divider is stopped in the middle of a transfer, `sck_o` returns to 0 one cycle later.
- R7: When the divider becomes enabled, the count restarts from zero, whatever state an earlier aborted transfer left. The first strobe is seen in the enabled cycle numbered period/2 - 1, counting the first enabled cycle as 0.
- R8: `sck_o` inverts in the cycle after each strobe and holds its value in all other enabled cycles.
- R9: A change to either field during a transfer does not alter the half-period in progress. The new length applies from the next terminal count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| presel_i | input | 3 | Linear divisor field; factor is value + 1 |
| sel_i | input | 3 | Exponent field; factor is 2^(value + 1) |
| master_i | input | 1 | Block is operating as master |
| xfer_i | input | 1 | A serial transfer is in progress |
| sck_tick_o | output | 1 | One-cycle strobe at each SCK half-period boundary |
| sck_o | output | 1 | Divided serial clock level |

## Verification
The divider is driven with the all-zero setting, with pure exponent settings (periods 4 and 8), with pure linear settings (periods 4, 6 and 10), and with the maximum setting (period 2048). Together these settings separate the linear term from the power-of-two term, and they show whether either term is off by one. Each run also checks the delay to the first strobe, which shows that the counter restarts from zero.

Gating is tried with each enable low on its own, and with an abort in the middle of a transfer followed by a restart. A further sequence changes the exponent field in the middle of a half-period. This shows whether the new length is applied at once or only at the next boundary.

// File: rtl/spi_baud_div.sv
module spi_baud_div #(
  parameter int PRE_W = 3,
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PRE_W-1:0] presel_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             master_i,
  input  logic             xfer_i,
  output logic             sck_tick_o,
  output logic             sck_o
);
  localparam int HP_W = PRE_W + (1 << SEL_W);

  logic            run;
  logic            term;
  logic [HP_W-1:0] half_d, half_q, cnt_q;

  assign run        = master_i & xfer_i;
  assign half_d     = HP_W'({1'b0, presel_i} + (PRE_W+1)'(1)) << sel_i;
  assign term       = (cnt_q == half_q - HP_W'(1));
  assign sck_tick_o = run & term;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      half_q <= HP_W'(1);
      sck_o  <= 1'b0;
    end else if (!run) begin
      cnt_q  <= '0;
      half_q <= half_d;
      sck_o  <= 1'b0;
    end else if (term) begin
      cnt_q  <= '0;
      half_q <= half_d;
      sck_o  <= ~sck_o;
    end else begin
      cnt_q  <= cnt_q + HP_W'(1);
    end
  end

  // R6
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> !sck_o);

  // R8
  toggle_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_tick_o |=> sck_o != $past(sck_o));

  // R8
  hold_between_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !sck_tick_o) |=> $stable(sck_o));

  // R9
  half_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !sck_tick_o) |=> $stable(half_q));

  // R5
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < half_q);

  // R7
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> cnt_q == '0);
endmodule

// File: tb/spi_baud_div_tb.sv
module spi_baud_div_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] pre = '0, sel = '0;
  logic master = 1'b0, xfer = 1'b0;
  logic tick, sck;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  spi_baud_div dut_i (
    .clk_i(clk), .rst_ni(rst_n), .presel_i(pre), .sel_i(sel),
    .master_i(master), .xfer_i(xfer), .sck_tick_o(tick), .sck_o(sck)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic stop_div();
    @(negedge clk); master = 0; xfer = 0;
    @(negedge clk);
  endtask

  // Runs one enabled window and checks the first strobe, the spacing and the sck level.
  task automatic run_div(input string req, input int p, input int s);
    int h, first, ntick, last, gapbad, sckbad;
    h = (p + 1) << s;
    first = -1; ntick = 0; last = -1; gapbad = 0; sckbad = 0;
    stop_div();
    pre = 3'(p); sel = 3'(s);
    @(negedge clk); master = 1; xfer = 1;
    for (int i = 0; i < 4*h; i++) begin
      #1;
      if (sck !== 1'(ntick % 2)) sckbad++;
      if (tick) begin
        if (first < 0) first = i;
        if (last >= 0 && i - last != h) gapbad++;
        last = i; ntick++;
      end
      @(negedge clk);
    end
    chk({req, " first strobe (R7)"}, first, h - 1);
    chk({req, " strobe count"}, ntick, 4);
    chk({req, " strobe spacing"}, gapbad, 0);
    chk({req, " sck level (R8)"}, sckbad, 0);
    stop_div();
  endtask

  task automatic t_reset();
    #1;
    chk("R1 sck after reset", int'(sck), 0);
    chk("R1 tick after reset", int'(tick), 0);
  endtask

  task automatic t_gating();
    int bad;
    stop_div();
    pre = 0; sel = 0;
    bad = 0;
    @(negedge clk); master = 1; xfer = 0;
    for (int i = 0; i < 20; i++) begin #1; if (tick || sck) bad++; @(negedge clk); end
    chk("R6 master only", bad, 0);
    bad = 0;
    master = 0; xfer = 1;
    for (int i = 0; i < 20; i++) begin #1; if (tick || sck) bad++; @(negedge clk); end
    chk("R6 transfer only", bad, 0);
    stop_div();
    pre = 0; sel = 2;
    @(negedge clk); master = 1; xfer = 1;
    for (int i = 0; i < 5; i++) @(negedge clk);
    #1; chk("R6 sck high before abort", int'(sck), 1);
    master = 0;
    @(negedge clk); #1;
    chk("R6 sck low after abort", int'(sck), 0);
    @(negedge clk); master = 1;
    begin
      int first;
      first = -1;
      for (int i = 0; i < 8; i++) begin
        #1; if (tick && first < 0) first = i;
        @(negedge clk);
      end
      chk("R7 first strobe after restart", first, 3);
    end
    stop_div();
  endtask

  task automatic t_change();
    int idx[$];
    stop_div();
    pre = 0; sel = 2;
    @(negedge clk); master = 1; xfer = 1;
    for (int i = 0; i < 21; i++) begin
      if (i == 2) sel = 3;
      #1;
      if (tick) idx.push_back(i);
      @(negedge clk);
    end
    chk("R9 strobe count", idx.size(), 3);
    if (idx.size() == 3) begin
      chk("R9 current half kept", idx[0], 3);
      chk("R9 new length next", idx[1], 11);
      chk("R9 new length after", idx[2], 19);
    end
    stop_div();
  endtask

  initial begin
    #200000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    rst_n = 1;
    run_div("R2 div2", 0, 0);
    run_div("R3 div4 by exponent", 0, 1);
    run_div("R3 div8 by exponent", 0, 2);
    run_div("R4 div4 by linear", 1, 0);
    run_div("R4 div6", 2, 0);
    run_div("R4 div10", 4, 0);
    run_div("R4 mixed div24", 2, 2);
    run_div("R5 div2048", 7, 7);
    t_gating();
    t_change();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule